// File: doc/BRIEF.md
# Wireless Frame Depackager Controller

This block sits between a baseband decoder and a small microprocessor. The decoder offers bytes of a short wireless frame one at a time, raising a ready-to-send line; the controller takes a byte in every cycle where it answers with ready-to-receive. The controller skips the first five header bytes. It takes the sixth as the frame length and then stores that many body bytes in an on-chip 256 x 8 RAM. The body is placed from the top of the length range downward, so the last body byte lands at address 0.

While the body arrives, a 16-bit checksum runs over it. After the last byte the controller stores the length and both checksum bytes at fixed high addresses. It then hands the RAM to the processor. The processor reads through an 8-bit address, a request line and an acknowledge line, as many times as it likes. An access to a reserved exit address tells the controller that reading is over. The controller then goes back to waiting for the next frame.

Top module: `frame_unpack`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge) rx_rtr and cpu_ack are 0, the controller waits for header bytes with its header count at zero and the checksum cleared.
- R2: rx_rtr follows rx_rts in the same cycle only while the controller is taking header or body bytes; a byte on rx_data is consumed at each rising edge where rx_rts and rx_rtr are both 1, and at no other edge.
- R3: The sixth consumed byte of a frame is its length; only its low 7 bits (0 to 127) are used, bit 7 is ignored.
- R4: One cycle after the length byte is consumed, the 7-bit length (bit 7 written as 0) is stored at RAM address 8'h80; rx_rtr is 0 in that cycle.
- R5: With length L, the k-th body byte (k = 1..L) is stored at address L-k; reception ends after the byte at address 0, and L = 0 stores no body byte.
- R6: The checksum uses polynomial x^16+x^12+x^5+1, starts at 0, takes each body byte least significant bit first and is not inverted (per bit: feedback = crc[0] xor data bit; shift right; xor 16'h8408 when feedback is 1). Header and length bytes do not enter it. Its low byte is stored at 8'h81 and its high byte at 8'h82 in the two cycles after reception ends.
- R7: In the read phase cpu_ack equals cpu_req of the previous cycle, and while cpu_ack is 1 cpu_rdata holds the RAM byte at the cpu_addr sampled one cycle earlier.
- R8: A request to address 8'hFF returns 8'h00 and ends the read phase: once cpu_req falls, cpu_ack falls at the next edge and the controller returns to waiting for a header with its count and checksum cleared.
- R9: rx_rts during the read phase is ignored: rx_rtr stays 0 and no byte is consumed, so the next frame's header count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Byte offered by the decoder |
| rx_rts | input | 1 | Decoder has a byte ready |
| rx_rtr | output | 1 | Controller consumes the offered byte this cycle |
| cpu_addr | input | 8 | Processor read address |
| cpu_req | input | 1 | Processor read request |
| cpu_ack | output | 1 | Read acknowledge, one cycle after request |
| cpu_rdata | output | 8 | Read data, valid while cpu_ack is 1 |

## Verification
On every cycle the assertions check a few rules. Body write addresses stay below the stored length. The last body byte leads into the checksum writes, and the two checksum writes follow each other. Acknowledge drops one cycle after request falls. Acknowledge and ready-to-receive are never high together. The controller leaves the read phase once the exit address has been seen and the request has dropped. Data placement, the checksum values, the masking of the length's top bit and the fact that ignored bytes leave no trace can only be seen through the bench's frames and reads. The bench compares every cycle against a behavioural model.

// File: rtl/fu_pkg.sv
package fu_pkg;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_LENW,
        ST_BODY,
        ST_CLO,
        ST_CHI,
        ST_READ
    } fu_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } fu_wr_t;

    localparam logic [7:0] FU_LEN_ADDR  = 8'h80;
    localparam logic [7:0] FU_CLO_ADDR  = 8'h81;
    localparam logic [7:0] FU_CHI_ADDR  = 8'h82;
    localparam logic [7:0] FU_EXIT_ADDR = 8'hFF;
    localparam int         FU_LEN_POS   = 6;

    // one byte into the reflected x^16+x^12+x^5+1 checksum, lsb first
    function automatic logic [15:0] fu_crc_byte(logic [15:0] c, logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = {1'b0, r[15:1]} ^ (fb ? 16'h8408 : 16'h0000);
        end
        return r;
    endfunction

endpackage

// File: rtl/fu_crc16.sv
module fu_crc16 import fu_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            crc <= 16'h0000;
        else if (en)
            crc <= fu_crc_byte(crc, din);
    end
endmodule

// File: rtl/fu_sram.sv
module fu_sram #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        if (re)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/fu_ctrl.sv
module fu_ctrl import fu_pkg::*; #(
    parameter int AW      = 8,
    parameter int LEN_POS = FU_LEN_POS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_rts,
    input  logic [7:0]    rx_data,
    output logic          rx_rtr,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    output logic          cpu_ack,
    input  logic [15:0]   crc,
    output logic          crc_en,
    output logic          crc_clr,
    output fu_wr_t        wr,
    output logic          rd_mode,
    output logic          rd_en,
    output logic          exit_rd
);
    localparam int LW  = AW - 1;
    localparam int HCW = $clog2(LEN_POS);
    localparam logic [HCW-1:0] HC_LAST = HCW'(LEN_POS - 1);

    fu_state_e     st;
    logic [HCW-1:0] hcnt;
    logic [LW-1:0]  len_q;
    logic [AW-1:0]  cnt_q;
    logic           exam_q;

    always_comb begin
        rx_rtr  = rx_rts && (st == ST_HDR || st == ST_BODY);
        crc_en  = (st == ST_BODY) && rx_rtr;
        crc_clr = (st == ST_READ) && !cpu_req && !exam_q;
        rd_mode = (st == ST_READ);
        rd_en   = (st == ST_READ) && cpu_req;
        wr      = '0;
        unique case (st)
            ST_LENW: wr = '{en: 1'b1, addr: FU_LEN_ADDR, data: {1'b0, len_q}};
            ST_BODY: wr = '{en: rx_rtr, addr: cnt_q - 1'b1, data: rx_data};
            ST_CLO:  wr = '{en: 1'b1, addr: FU_CLO_ADDR, data: crc[7:0]};
            ST_CHI:  wr = '{en: 1'b1, addr: FU_CHI_ADDR, data: crc[15:8]};
            default: wr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_HDR;
            hcnt    <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            exam_q  <= 1'b0;
            cpu_ack <= 1'b0;
            exit_rd <= 1'b0;
        end else begin
            unique case (st)
                ST_HDR: if (rx_rtr) begin
                    if (hcnt == HC_LAST) begin
                        len_q <= rx_data[LW-1:0];
                        st    <= ST_LENW;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_LENW: begin
                    cnt_q <= {1'b0, len_q};
                    st    <= (len_q == '0) ? ST_CLO : ST_BODY;
                end
                ST_BODY: if (rx_rtr) begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == AW'(1))
                        st <= ST_CLO;
                end
                ST_CLO: st <= ST_CHI;
                ST_CHI: begin
                    exam_q <= 1'b1;
                    st     <= ST_READ;
                end
                ST_READ: begin
                    if (cpu_req) begin
                        cpu_ack <= 1'b1;
                        exit_rd <= (cpu_addr == FU_EXIT_ADDR);
                        if (cpu_addr == FU_EXIT_ADDR)
                            exam_q <= 1'b0;
                    end else begin
                        cpu_ack <= 1'b0;
                        if (!exam_q) begin
                            st   <= ST_HDR;
                            hcnt <= '0;
                        end
                    end
                end
                default: st <= ST_HDR;
            endcase
        end
    end

    // R5: body bytes land strictly below the stored length
    a_r5_body_addr_below_len: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BODY && rx_rtr) |-> (wr.addr < {1'b0, len_q}));

    // R5: the write to address 0 closes reception
    a_r5_last_byte_ends_body: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BODY && rx_rtr && wr.addr == '0) |=> (st == ST_CLO));

    // R6: checksum high byte write follows the low byte write
    a_r6_crc_pair: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == FU_CLO_ADDR) |=> (wr.en && wr.addr == FU_CHI_ADDR));

    // R7: acknowledge drops one cycle after request falls
    a_r7_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
        (rd_mode && !cpu_req) |=> !cpu_ack);

    // R8: exit seen and request gone -> back to header search
    a_r8_exit_to_hdr: assert property (@(posedge clk) disable iff (rst)
        (rd_mode && !exam_q && !cpu_req) |=> (st == ST_HDR && hcnt == '0));

    // R9: never take a byte while a processor read is acknowledged
    a_r9_no_rtr_while_ack: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> !rx_rtr);

endmodule

// File: rtl/frame_unpack.sv
module frame_unpack import fu_pkg::*; #(
    parameter int DW      = 8,
    parameter int AW      = 8,
    parameter int LEN_POS = FU_LEN_POS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_rts,
    output logic          rx_rtr,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_req,
    output logic          cpu_ack,
    output logic [DW-1:0] cpu_rdata
);
    logic [15:0]   crc;
    logic          crc_en;
    logic          crc_clr;
    fu_wr_t        wr;
    logic          rd_mode;
    logic          rd_en;
    logic          exit_rd;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_q;

    fu_ctrl #(.AW(AW), .LEN_POS(LEN_POS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rx_rts   (rx_rts),
        .rx_data  (rx_data),
        .rx_rtr   (rx_rtr),
        .cpu_req  (cpu_req),
        .cpu_addr (cpu_addr),
        .cpu_ack  (cpu_ack),
        .crc      (crc),
        .crc_en   (crc_en),
        .crc_clr  (crc_clr),
        .wr       (wr),
        .rd_mode  (rd_mode),
        .rd_en    (rd_en),
        .exit_rd  (exit_rd)
    );

    fu_crc16 u_crc (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .en  (crc_en),
        .din (rx_data),
        .crc (crc)
    );

    // single RAM port: processor address in read phase, write address otherwise
    assign ram_addr = rd_mode ? cpu_addr : wr.addr;

    fu_sram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (wr.en),
        .re    (rd_en),
        .addr  (ram_addr),
        .wdata (wr.data),
        .rdata (ram_q)
    );

    assign cpu_rdata = exit_rd ? '0 : ram_q;

endmodule

// File: tb/frame_unpack_test.sv
module frame_unpack_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_data = 8'h00;
    logic       rx_rts = 1'b0;
    logic       rx_rtr;
    logic [7:0] cpu_addr = 8'h00;
    logic       cpu_req = 1'b0;
    logic       cpu_ack;
    logic [7:0] cpu_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    frame_unpack uut (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_rts(rx_rts), .rx_rtr(rx_rtr),
        .cpu_addr(cpu_addr), .cpu_req(cpu_req), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] x;
        x = c ^ {8'h00, d};
        for (int k = 0; k < 8; k++)
            x = x[0] ? ((x >> 1) ^ 16'h8408) : (x >> 1);
        return x;
    endfunction

    logic [7:0] mmem [int];
    int          ph;          // 0 hdr, 1 len, 2 body, 3 crc lo, 4 crc hi, 5 read
    int          hc, ln, cn;
    logic [15:0] mcrc;
    bit          mexam, mack, mknown;
    logic [7:0]  mexp;
    int          maddr;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; hc = 0; mcrc = 16'h0; mexam = 0; mack = 0; mknown = 0;
        end else begin
            case (ph)
                0: if (rx_rts) begin
                    if (hc == 5) begin ln = int'(rx_data) % 128; ph = 1; end
                    else hc++;
                end
                1: begin mmem[128] = 8'(ln); cn = ln; ph = (ln == 0) ? 3 : 2; end
                2: if (rx_rts) begin
                    mmem[cn - 1] = rx_data; mcrc = ref_crc(mcrc, rx_data); cn--;
                    if (cn == 0) ph = 3;
                end
                3: begin mmem[129] = mcrc[7:0]; ph = 4; end
                4: begin mmem[130] = mcrc[15:8]; mexam = 1; ph = 5; end
                default: begin
                    if (cpu_req) begin
                        mack = 1; maddr = int'(cpu_addr);
                        if (cpu_addr == 8'hFF) begin mexp = 8'h00; mknown = 1; mexam = 0; end
                        else if (mmem.exists(maddr)) begin mexp = mmem[maddr]; mknown = 1; end
                        else mknown = 0;
                    end else begin
                        mack = 0;
                        if (!mexam) begin ph = 0; hc = 0; mcrc = 16'h0; end
                    end
                end
            endcase
        end
    end

    function automatic string addr_tag(int a);
        if (a == 255) return "R8";
        if (a == 128) return "R4/R3";
        if (a == 129 || a == 130) return "R6";
        return "R5";
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #3;
        if (!rst && !finished) begin
            check((ph == 5) ? "R9 rtr in read" : "R2 rtr",
                  int'(rx_rtr), int'(rx_rts && (ph == 0 || ph == 2)));
            check("R7 ack", int'(cpu_ack), int'(mack));
            if (mack && mknown)
                check({addr_tag(maddr), " rdata"}, int'(cpu_rdata), int'(mexp));
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_byte(input logic [7:0] b, input int gap);
        rx_rts = 1'b1; rx_data = b;
        #1;
        while (!rx_rtr) begin @(negedge clk); #1; end
        @(negedge clk);
        rx_rts = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] lenb, input int seed);
        for (int i = 0; i < 5; i++) send_byte(8'(8'hA0 + i), i % 2);
        send_byte(lenb, 0);
        for (int i = 0; i < int'(lenb[6:0]); i++)
            send_byte(8'(seed * 37 + i * 11 + 3), (i % 3 == 0) ? 1 : 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic cpu_read(input logic [7:0] a);
        cpu_req = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_all(input int n);
        for (int i = 0; i < n; i++) cpu_read(8'(i));
        cpu_read(8'h80); cpu_read(8'h81); cpu_read(8'h82);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #3;
        check("R1 rtr after reset", int'(rx_rtr), 0);
        check("R1 ack after reset", int'(cpu_ack), 0);
        @(negedge clk);

        // frame A: 4 body bytes, rts noise during read phase
        send_frame(8'h04, 1);
        read_all(4);
        rx_rts = 1'b1; rx_data = 8'h55;         // R9 stimulus: ignored
        repeat (5) @(negedge clk);
        rx_rts = 1'b0;
        cpu_read(8'h02);
        cpu_read(8'hFF);                         // R8 exit
        #3; check("R8 ack low after exit", int'(cpu_ack), 0);
        @(negedge clk);

        // frame B: length byte with bit 7 set -> 3 (R3)
        send_frame(8'h83, 2);
        read_all(3);
        cpu_read(8'hFF);
        @(negedge clk);

        // frame C: zero length, checksum stays 0 (R5, R6)
        send_frame(8'h00, 3);
        cpu_read(8'h80); cpu_read(8'h81); cpu_read(8'h82);
        cpu_req = 1'b1; cpu_addr = 8'hFF;        // hold request over exit
        repeat (3) @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);

        // frame D: longest length 127
        send_frame(8'h7F, 4);
        read_all(127);
        cpu_read(8'hFF);
        repeat (2) @(negedge clk);

        // R1: reset mid-header, then a clean frame
        send_byte(8'h11, 0); send_byte(8'h22, 0);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        #3; check("R1 rtr after mid-frame reset", int'(rx_rtr), 0);
        @(negedge clk);
        send_frame(8'h02, 5);
        read_all(2);
        cpu_read(8'hFF);
        repeat (2) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule